// File: doc/BRIEF.md
# ADC Sample Sequencer Result FIFOs

This block is the digital back end of a converter with four sample sequencers. Each sequencer owns a 16-deep result queue. Software reads a queue through a pop register and watches it through a status word that packs both pointers and the empty and full flags. A single-cycle trigger pulse, standing in for a timer event, makes every sequencer that is switched on and has its event selector set to the timer code capture one result. Each capture also raises that sequencer's raw interrupt bit.

No analog converter sits behind the block. Each captured value is produced by a 32-bit pseudo-random state. When several sequencers capture on one pulse, they take successive states in ascending index order. Each sequencer drives its own interrupt line: the raw bit gated by a mask bit. Software clears raw bits by writing ones to the clear register. The register port is a simple single-cycle write strobe plus a combinational read, where a read strobe marks the read that pops a queue.

Top module: `adc_seq_fifo`

## Requirements
- R1: After reset, every status word reads 0x100 (empty, both pointers 0). The enable, raw, mask and event registers read 0, and all interrupt lines are low.
- R2: A status word holds the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12. Empty and full are never set together, and either flag implies equal pointers.
- R3: A read strobe on a pop register (0x48 + n*0x20) returns the oldest entry and advances the read pointer modulo 16. It clears full and sets empty once the pointers meet. A pop of an empty queue returns 0 and leaves the status word unchanged.
- R4: A capture stores at the write pointer and advances it modulo 16. It clears empty and sets full once the pointers meet. A capture into a full queue is dropped and leaves the status word unchanged.
- R5: On a trigger pulse, sequencer n captures only if enable bit n (register 0x00) is set and nibble n of the event register (0x14, bits 4n+3:4n) equals 5.
- R6: Each capture first updates the random state to state*314159+1 (mod 2^32), starting from 0 at reset. The captured value is 0x200 plus bits 18:16 of the new state. Sequencers capturing on one pulse are served in ascending index order.
- R7: Every capture sets raw bit n (register 0x04), including a capture dropped on a full queue. Raw bits change only through captures and clears.
- R8: Interrupt line n is raw bit n AND mask bit n (mask register 0x08, 4 bits). Reading 0x0C returns raw AND mask.
- R9: Writing to 0x0C clears each raw bit whose data bit is 1. A capture in the same cycle wins.
- R10: The enable register keeps only bits 3:0. The input-select register (0x40 + n*0x20) stores write data AND 0x33333333. The control register (0x44 + n*0x20) stores all 32 bits. Status is at 0x4C + n*0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe; pops a queue when addressing a pop register |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| trig_pulse | input | 1 | Timer event, one cycle wide per event |
| irq | output | 4 | Per-sequencer interrupt lines |

## Verification
The interrupt and raw-bit properties assume that only a trigger pulse or a mask write can raise a line. They also assume a clear write means what it says only when no trigger shares its cycle. The stimulus therefore never places a register write and a trigger in the same cycle. The one deliberate overlap is a pop coinciding with a capture, which the queue-ordering rule (pop before push) defines. Reads are issued one at a time with the strobe held for exactly one cycle, so each pop strobe stands for exactly one software read.

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int NSEQ     = 4,
  parameter int DEPTH    = 16,
  parameter int DW       = 10,
  parameter int AW       = 8,
  parameter int TRIG_SEL = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            trig_pulse,
  output logic [NSEQ-1:0] irq
);

  localparam int PW = $clog2(DEPTH);
  localparam int SW = (NSEQ > 1) ? $clog2(NSEQ) : 1;
  localparam int EW = 4 * NSEQ;
  localparam logic [AW-1:0] A_EN    = AW'('h00);
  localparam logic [AW-1:0] A_RAW   = AW'('h04);
  localparam logic [AW-1:0] A_MASK  = AW'('h08);
  localparam logic [AW-1:0] A_CLR   = AW'('h0C);
  localparam logic [AW-1:0] A_EVT   = AW'('h14);
  localparam logic [AW-1:0] A_SEQ0  = AW'('h40);
  localparam logic [AW-1:0] SEQ_SPAN = AW'(NSEQ * 32);

  logic [NSEQ-1:0] en_r, raw_r, mask_r, cap, clr;
  logic [EW-1:0]   evt_r;
  logic [31:0]     sel_r [NSEQ];
  logic [31:0]     ctl_r [NSEQ];
  logic [31:0]     rnd_r, rnd_nxt;
  logic [DW-1:0]   smp   [NSEQ];
  logic [DW-1:0]   front [NSEQ];
  logic [NSEQ-1:0] emp_v, ful_v;
  logic [NSEQ*PW-1:0] head_v, tail_v;

  logic [AW-1:0] seq_off;
  logic          seq_hit;
  logic [SW-1:0] seq_sel;
  logic [4:0]    seq_reg;

  assign seq_off = bus_addr - A_SEQ0;
  assign seq_hit = (bus_addr >= A_SEQ0) && (seq_off < SEQ_SPAN);
  assign seq_sel = seq_off[SW+4:5];
  assign seq_reg = seq_off[4:0];

  always_comb begin
    logic [31:0] s;
    s = rnd_r;
    for (int n = 0; n < NSEQ; n++) begin
      cap[n] = trig_pulse && en_r[n] && (evt_r[4*n +: 4] == 4'(TRIG_SEL));
      if (cap[n]) s = s * 32'd314159 + 32'd1;
      smp[n] = DW'(32'h200 + {29'd0, s[18:16]});
    end
    rnd_nxt = s;
  end

  for (genvar g = 0; g < NSEQ; g++) begin : g_fifo
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] tail, head, tail_n, head_n;
    logic          emp, ful, emp_n, ful_n, pop, push;

    assign pop = bus_rd && seq_hit && (seq_reg == 5'h08) && (seq_sel == SW'(g));

    always_comb begin
      tail_n = tail;
      head_n = head;
      emp_n  = emp;
      ful_n  = ful;
      push   = 1'b0;
      if (pop && !emp) begin
        tail_n = tail + 1'b1;
        ful_n  = 1'b0;
        emp_n  = (tail_n == head);
      end
      if (cap[g] && !ful_n) begin
        push   = 1'b1;
        head_n = head + 1'b1;
        emp_n  = 1'b0;
        ful_n  = (head_n == tail_n);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tail <= '0;
        head <= '0;
        emp  <= 1'b1;
        ful  <= 1'b0;
      end else begin
        tail <= tail_n;
        head <= head_n;
        emp  <= emp_n;
        ful  <= ful_n;
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[head] <= smp[g];
    end

    assign front[g]            = emp ? '0 : mem[tail];
    assign emp_v[g]            = emp;
    assign ful_v[g]            = ful;
    assign head_v[g*PW +: PW]  = head;
    assign tail_v[g*PW +: PW]  = tail;
  end

  function automatic logic [31:0] status_word(input int n);
    logic [31:0] w;
    w = '0;
    w[PW-1:0]   = tail_v[n*PW +: PW];
    w[4 +: PW]  = head_v[n*PW +: PW];
    w[8]        = emp_v[n];
    w[12]       = ful_v[n];
    return w;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (seq_hit) begin
      case (seq_reg)
        5'h00:   bus_rdata = sel_r[seq_sel];
        5'h04:   bus_rdata = ctl_r[seq_sel];
        5'h08:   bus_rdata = 32'(front[seq_sel]);
        5'h0C:   bus_rdata = status_word(int'(seq_sel));
        default: bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        A_EN:    bus_rdata = 32'(en_r);
        A_RAW:   bus_rdata = 32'(raw_r);
        A_MASK:  bus_rdata = 32'(mask_r);
        A_CLR:   bus_rdata = 32'(raw_r & mask_r);
        A_EVT:   bus_rdata = 32'(evt_r);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign clr = (bus_wr && !seq_hit && bus_addr == A_CLR) ? bus_wdata[NSEQ-1:0] : '0;
  assign irq = raw_r & mask_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r   <= '0;
      mask_r <= '0;
      raw_r  <= '0;
      evt_r  <= '0;
      rnd_r  <= '0;
      for (int n = 0; n < NSEQ; n++) begin
        sel_r[n] <= '0;
        ctl_r[n] <= '0;
      end
    end else begin
      rnd_r <= rnd_nxt;
      raw_r <= (raw_r & ~clr) | cap;
      if (bus_wr) begin
        if (seq_hit) begin
          if (seq_reg == 5'h00) sel_r[seq_sel] <= bus_wdata & 32'h3333_3333;
          if (seq_reg == 5'h04) ctl_r[seq_sel] <= bus_wdata;
        end else begin
          if (bus_addr == A_EN)   en_r   <= bus_wdata[NSEQ-1:0];
          if (bus_addr == A_MASK) mask_r <= bus_wdata[NSEQ-1:0];
          if (bus_addr == A_EVT)  evt_r  <= bus_wdata[EW-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/adc_seq_fifo_chk.sv
module adc_seq_fifo_chk #(
  parameter int NSEQ = 4,
  parameter int PW   = 4,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [NSEQ-1:0] clr_bits,
  input logic            trig_pulse,
  input logic [NSEQ-1:0] irq,
  input logic [NSEQ-1:0] raw,
  input logic [NSEQ-1:0] emp_v,
  input logic [NSEQ-1:0] ful_v,
  input logic [NSEQ*PW-1:0] head_v,
  input logic [NSEQ*PW-1:0] tail_v
);

  localparam logic [AW-1:0] A_MASK = AW'('h08);
  localparam logic [AW-1:0] A_CLR  = AW'('h0C);

  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == A_CLR);

  assert_raw_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_pulse && !clr_wr) |=> $stable(raw));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !trig_pulse) |=> ((raw & $past(clr_bits)) == '0));

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq)) != '0) |-> $past(trig_pulse || (bus_wr && bus_addr == A_MASK)));

  for (genvar g = 0; g < NSEQ; g++) begin : g_q
    logic pop_g;
    assign pop_g = bus_rd && (bus_addr == AW'('h48 + g * 32));

    assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(emp_v[g] && ful_v[g]));

    assert_flag_ptrs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (emp_v[g] || ful_v[g]) |-> (head_v[g*PW +: PW] == tail_v[g*PW +: PW]));

    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (emp_v[g] && pop_g && !trig_pulse) |=> (emp_v[g] && $stable(tail_v[g*PW +: PW])));

    assert_full_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ful_v[g] && !pop_g) |=> (ful_v[g] && $stable(head_v[g*PW +: PW])));
  end

endmodule

bind adc_seq_fifo adc_seq_fifo_chk #(.NSEQ(NSEQ), .PW(PW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .clr_bits   (bus_wdata[NSEQ-1:0]),
  .trig_pulse (trig_pulse),
  .irq        (irq),
  .raw        (raw_r),
  .emp_v      (emp_v),
  .ful_v      (ful_v),
  .head_v     (head_v),
  .tail_v     (tail_v)
);

// File: tb/adc_seq_fifo_tb.sv
module adc_seq_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, trig = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  always #2 clk = ~clk;

  adc_seq_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .trig_pulse(trig), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  int unsigned m_rnd, m_en, m_raw, m_mask, m_evt;
  int unsigned m_sel [4];
  int unsigned m_ctl [4];
  int unsigned m_q   [4][$];
  int unsigned m_head[4];
  int unsigned m_tail[4];

  function automatic int unsigned m_stat(int n);
    return m_tail[n] | (m_head[n] << 4) |
           ((m_q[n].size() == 0) ? 32'h100 : 0) |
           ((m_q[n].size() == 16) ? 32'h1000 : 0);
  endfunction

  function automatic int unsigned m_read(int a);
    if (a >= 'h40 && a < 'hC0) begin
      int n;
      n = (a - 'h40) >> 5;
      case (a & 31)
        0:  return m_sel[n];
        4:  return m_ctl[n];
        8:  return (m_q[n].size() > 0) ? m_q[n][0] : 0;
        12: return m_stat(n);
        default: return 0;
      endcase
    end
    case (a)
      'h00: return m_en;
      'h04: return m_raw;
      'h08: return m_mask;
      'h0C: return m_raw & m_mask;
      'h14: return m_evt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int unsigned capb, clrb;
    capb = 0;
    clrb = 0;
    if (!rst_n) begin
      m_rnd = 0; m_en = 0; m_raw = 0; m_mask = 0; m_evt = 0;
      for (int n = 0; n < 4; n++) begin
        m_sel[n] = 0; m_ctl[n] = 0; m_q[n].delete(); m_head[n] = 0; m_tail[n] = 0;
      end
    end else begin
      if (bus_rd && addr >= 'h40 && addr < 'hC0 && (addr & 31) == 8) begin
        int n;
        n = (int'(addr) - 'h40) >> 5;
        if (m_q[n].size() > 0) begin
          void'(m_q[n].pop_front());
          m_tail[n] = (m_tail[n] + 1) % 16;
        end
      end
      if (trig) begin
        for (int n = 0; n < 4; n++) begin
          if (((m_en >> n) & 1) == 1 && ((m_evt >> (4 * n)) & 15) == 5) begin
            m_rnd = m_rnd * 32'd314159 + 32'd1;
            if (m_q[n].size() < 16) begin
              m_q[n].push_back(32'h200 + ((m_rnd >> 16) & 7));
              m_head[n] = (m_head[n] + 1) % 16;
            end
            capb |= (1 << n);
          end
        end
      end
      if (bus_wr) begin
        if (addr >= 'h40 && addr < 'hC0) begin
          int n;
          n = (int'(addr) - 'h40) >> 5;
          if ((addr & 31) == 0) m_sel[n] = wdata & 32'h3333_3333;
          if ((addr & 31) == 4) m_ctl[n] = wdata;
        end else begin
          case (addr)
            'h00: m_en   = wdata & 15;
            'h08: m_mask = wdata & 15;
            'h0C: clrb   = wdata & 15;
            'h14: m_evt  = wdata & 16'hFFFF;
            default: ;
          endcase
        end
      end
      m_raw = (m_raw & ~clrb) | capb;
    end
  end

  task automatic check(string tag, int unsigned got, int unsigned exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check("R8 irq lines", 32'(irq), m_raw & m_mask);
  end

  task automatic wr(int a, int unsigned d);
    @(negedge clk);
    addr = 8'(a); wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, int a);
    @(negedge clk);
    addr = 8'(a); bus_rd = 1'b1;
    #1 check(tag, rdata, m_read(a));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after reset", 32'(irq), 0);
    for (int n = 0; n < 4; n++) rd("R1 status after reset", 'h4C + 32 * n);
    check("R1 model empty word", m_stat(0), 32'h100);
    rd("R1 enable", 'h00);
    rd("R1 raw", 'h04);
    rd("R1 event", 'h14);

    wr('h00, 32'hFF);
    rd("R10 enable keeps 4 bits", 'h00);
    wr('h40, 32'hFFFF_FFFF);
    rd("R10 select mask", 'h40);
    wr('h64, 32'hABCD_1234);
    rd("R10 control store", 'h64);

    rd("R3 pop empty returns 0", 'h48);
    rd("R3 pop empty keeps status", 'h4C);

    wr('h14, 32'h5355);
    wr('h00, 32'h7);
    pulse();
    for (int n = 0; n < 4; n++) rd("R5 gated capture status", 'h4C + 32 * n);
    rd("R7 raw after capture", 'h04);
    rd("R6 first value", 'h48);
    rd("R6 second sequencer value", 'h68);
    rd("R2 status after pop", 'h4C);

    wr('h08, 32'hF);
    rd("R8 masked read", 'h0C);
    wr('h0C, 32'h1);
    rd("R9 clear bit0", 'h04);

    wr('h00, 32'h1);
    repeat (20) pulse();
    rd("R4 full status", 'h4C);
    wr('h0C, 32'hF);
    rd("R9 clear all", 'h04);
    pulse();
    rd("R7 raw set on dropped capture", 'h04);
    rd("R4 dropped keeps status", 'h4C);
    for (int k = 0; k < 16; k++) rd("R3 pop order", 'h48);
    rd("R3 drained status", 'h4C);

    pulse();
    pulse();
    @(negedge clk);
    addr = 8'h48; bus_rd = 1'b1; trig = 1'b1;
    #1 check("R3 pop with capture", rdata, m_read('h48));
    @(negedge clk);
    bus_rd = 1'b0; trig = 1'b0;
    rd("R4 pop then push status", 'h4C);

    wr('h14, 32'h0500);
    wr('h00, 32'h4);
    pulse();
    rd("R5 third sequencer status", 'h8C);
    rd("R6 third sequencer value", 'h88);
    rd("R5 first sequencer untouched", 'h4C);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule